// File: doc/BRIEF.md
# Bit Scan and Count Unit

This unit runs the bit-search and bit-count operations of a 64-bit integer datapath. Each start pulse brings a source operand and a 3-bit operation code. Exactly one cycle later the unit presents a registered result, a destination write-enable, new values for six status flags and a mask of the flags that the operation defines.

Five operations are provided:

- A forward scan returns the position of the lowest set bit.
- A reverse scan returns the position of the highest set bit.
- A population count returns the number of ones.
- A trailing-zero count and a leading-zero count return 64 when the source is zero.

The two scans are different on a zero source. They leave the destination alone and signal the empty case only through the zero flag. The count operations always write a full-width result.

Operand fetch, decode and register writeback sit outside the block. The surrounding pipeline gates its destination write and flag merge with `dst_we` and `flag_mask`.

Top module: `bitscan_unit`

## Requirements
- R1: Operation codes are 0 forward scan, 1 reverse scan, 2 population count, 3 trailing-zero count and 4 leading-zero count. For codes 5 to 7 the valid pulse carries `illegal`=1, with `dst_we`=0, `flag_mask`=0, `result`=0 and `flags`=0.
- R2: A forward scan of a nonzero source returns the bit position of its lowest set bit and asserts `dst_we`.
- R3: A reverse scan of a nonzero source returns the bit position of its highest set bit, where 63 is the most significant position, and asserts `dst_we`.
- R4: A scan of a zero source keeps `dst_we` at 0, sets the zero flag and sets `flag_mask` to the zero-flag bit only.
- R5: Flag vectors use bit 0 carry, bit 1 parity, bit 2 auxiliary, bit 3 zero, bit 4 sign and bit 5 overflow. For a scan of a nonzero source, carry, overflow, auxiliary and zero are 0. Sign equals result bit 63. Parity is 1 when `result[7:0]` holds an even number of ones. `flag_mask` is all ones.
- R6: Population count returns the number of set bits and asserts `dst_we`. Zero is set only when the count is 0, every other flag is 0, and `flag_mask` is all ones.
- R7: Trailing-zero count and leading-zero count return 64 for a zero source. Otherwise they return the number of zero bits below the lowest set bit, or above the highest set bit.
- R8: For trailing-zero and leading-zero count, `dst_we` is 1 and carry is 1 exactly when the source is zero. Zero is 1 exactly when the result is zero, and `flag_mask` has only the carry and zero bits set.
- R9: After reset all outputs are 0. `valid` is high in the cycle after each cycle with `start` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request |
| op_sel | input | 3 | Operation code |
| src | input | 64 | Source operand |
| valid | output | 1 | Result pulse, one cycle after start |
| illegal | output | 1 | Unsupported operation code |
| dst_we | output | 1 | Destination write-enable |
| result | output | 64 | Operation result |
| flags | output | 6 | New status flag values |
| flag_mask | output | 6 | Flags defined by this operation |

## Verification
The registered outputs are loaded only on a start. A stale or wrong register therefore shows up at the ports in the valid cycle of the very next operation, as a bad result, write-enable or flag bit. A wrong index or count shows directly in `result`. Errors in the zero-source paths show as a destination write that should not happen, or a missing carry or zero bit. A fault in the handshake shows as a missing or extra valid pulse one cycle after start.

// File: rtl/bitscan_unit.sv
module bitscan_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] src,
  output logic         valid,
  output logic         illegal,
  output logic         dst_we,
  output logic [W-1:0] result,
  output logic [5:0]   flags,
  output logic [5:0]   flag_mask
);
  localparam int IW = $clog2(W + 1);
  localparam logic [5:0] M_ALL = 6'b111111;
  localparam logic [5:0] M_CZ  = 6'b001001;
  localparam logic [5:0] M_Z   = 6'b001000;

  logic [IW-1:0] lo_idx, hi_idx, ones;
  logic          nz;
  logic [W-1:0]  n_res;
  logic [5:0]    n_flg, n_msk;
  logic          n_we, n_ill;

  assign nz = |src;

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    ones   = '0;
    for (int i = W - 1; i >= 0; i--)
      if (src[i]) lo_idx = IW'(i);
    for (int i = 0; i < W; i++) begin
      if (src[i]) hi_idx = IW'(i);
      ones = ones + {{(IW-1){1'b0}}, src[i]};
    end
  end

  always_comb begin
    n_res = '0;
    n_flg = '0;
    n_msk = '0;
    n_we  = 1'b0;
    n_ill = 1'b0;
    case (op_sel)
      3'd0, 3'd1: begin
        if (nz) begin
          n_res = W'(op_sel[0] ? hi_idx : lo_idx);
          n_we  = 1'b1;
          n_msk = M_ALL;
          n_flg[1] = ~^n_res[7:0];
          n_flg[4] = n_res[W-1];
        end else begin
          n_msk = M_Z;
          n_flg[3] = 1'b1;
        end
      end
      3'd2: begin
        n_res = W'(ones);
        n_we  = 1'b1;
        n_msk = M_ALL;
        n_flg[3] = ~nz;
      end
      3'd3, 3'd4: begin
        n_res = nz ? W'(op_sel[2] ? IW'(W - 1) - hi_idx : lo_idx) : W'(W);
        n_we  = 1'b1;
        n_msk = M_CZ;
        n_flg[0] = ~nz;
        n_flg[3] = ~|n_res;
      end
      default: n_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      illegal   <= 1'b0;
      dst_we    <= 1'b0;
      result    <= '0;
      flags     <= '0;
      flag_mask <= '0;
    end else begin
      valid <= start;
      if (start) begin
        illegal   <= n_ill;
        dst_we    <= n_we;
        result    <= n_res;
        flags     <= n_flg;
        flag_mask <= n_msk;
      end
    end
  end
endmodule

// File: rtl/bitscan_unit_chk.sv
module bitscan_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [2:0]   op_sel,
  input logic [W-1:0] src,
  input logic         valid,
  input logic         illegal,
  input logic         dst_we,
  input logic [W-1:0] result,
  input logic [5:0]   flags,
  input logic [5:0]   flag_mask
);
  assert_valid_follows_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);
  assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel > 3'd4) |=> (illegal && !dst_we && flag_mask == 6'd0));
  assert_scan_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel < 3'd2 && src == '0) |=> (!dst_we && flags[3] && flag_mask == 6'b001000));
  assert_scan_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel < 3'd2 && src != '0) |=> (dst_we && result < W && !flags[3] && !flags[0]));
  assert_popcnt_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == 3'd2) |=> ((flags & 6'b110111) == 6'd0 && flags[3] == (result == '0)));
  assert_count_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_sel == 3'd3 || op_sel == 3'd4)) |=>
      (dst_we && flags[0] == (result == W) && flags[3] == (result == '0)));
endmodule

bind bitscan_unit bitscan_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .src(src),
  .valid(valid), .illegal(illegal), .dst_we(dst_we), .result(result),
  .flags(flags), .flag_mask(flag_mask)
);

// File: tb/sim_bitscan_unit.sv
module sim_bitscan_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [63:0] src = '0;
  logic        valid, illegal, dst_we;
  logic [63:0] result;
  logic [5:0]  flags, flag_mask;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitscan_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .src(src),
    .valid(valid), .illegal(illegal), .dst_we(dst_we), .result(result),
    .flags(flags), .flag_mask(flag_mask));

  localparam int NV = 16;
  localparam logic [2:0] VOP [NV] = '{
    3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd1, 3'd2, 3'd2,
    3'd2, 3'd3, 3'd3, 3'd3, 3'd4, 3'd4, 3'd4, 3'd0 };
  localparam logic [63:0] VSRC [NV] = '{
    64'h0000_0000_0000_0100, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0F0F_0000_0000_1003,
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0400_0000_0000,
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
    64'hA000_0000_0000_0000 };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [63:0] s,
      output logic [63:0] r, output logic we, output logic [5:0] f,
      output logic [5:0] m, output logic ill);
    logic [63:0] t;
    int n;
    r = 0; we = 0; f = 0; m = 0; ill = 0; t = s; n = 0;
    case (op)
      3'd0: if (s == 0) begin f = 6'b001000; m = 6'b001000; end
            else begin while (t[0] == 1'b0) begin t = t >> 1; n++; end
              r = 64'(n); we = 1; m = 6'b111111; f[1] = ~^r[7:0]; end
      3'd1: if (s == 0) begin f = 6'b001000; m = 6'b001000; end
            else begin n = 63; while (t[63] == 1'b0) begin t = t << 1; n--; end
              r = 64'(n); we = 1; m = 6'b111111; f[1] = ~^r[7:0]; end
      3'd2: begin while (t != 0) begin if (t[0]) n++; t = t >> 1; end
              r = 64'(n); we = 1; m = 6'b111111; f[3] = (n == 0); end
      3'd3, 3'd4: begin
              while (n < 64 && ((op == 3'd3) ? !t[0] : !t[63])) begin
                t = (op == 3'd3) ? t >> 1 : t << 1; n++; end
              r = 64'(n); we = 1; m = 6'b001001; f[0] = (s == 0); f[3] = (n == 0); end
      default: ill = 1;
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic [63:0] s, input string req);
    logic [63:0] er; logic ew, ei; logic [5:0] ef, em;
    model(op, s, er, ew, ef, em, ei);
    @(negedge clk); op_sel = op; src = s; start = 1'b1;
    @(negedge clk); start = 1'b0; op_sel = 3'd0; src = '0;
    check({req, " valid"}, 64'(valid), 64'd1);
    check({req, " result"}, result, er);
    check({req, " dst_we"}, 64'(dst_we), 64'(ew));
    check({req, " flags"}, 64'(flags), 64'(ef));
    check({req, " mask"}, 64'(flag_mask), 64'(em));
    check({req, " illegal"}, 64'(illegal), 64'(ei));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", 64'(valid), 64'd0);
    check("R9 reset result", result, 64'd0);
    check("R9 reset flags", 64'({dst_we, illegal, flags, flag_mask}), 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      string req;
      case (VOP[k])
        3'd0: req = (VSRC[k] == 0) ? "R4" : "R2";
        3'd1: req = (VSRC[k] == 0) ? "R4" : "R3";
        3'd2: req = "R6";
        default: req = (VSRC[k] == 0) ? "R7" : "R8";
      endcase
      run(VOP[k], VSRC[k], req);
    end
    run(3'd1, 64'h0000_0000_0000_0080, "R5");
    check("R5 parity odd index", 64'(flags[1]), 64'd0);
    run(3'd0, 64'h0000_0000_0000_0008, "R5");
    check("R5 parity even index", 64'(flags[1]), 64'd1);
    run(3'd3, 64'd0, "R7");
    check("R7 tz zero", result, 64'd64);
    run(3'd4, 64'd0, "R7");
    check("R7 lz zero", result, 64'd64);
    run(3'd4, 64'h0000_0000_0001_0000, "R8");
    check("R8 lz mid", result, 64'd47);
    for (int c = 5; c < 8; c++) run(3'(c), 64'hFFFF_0000_1234_5678, "R1");
    @(negedge clk);
    check("R9 single pulse", 64'(valid), 64'd0);
    @(negedge clk); op_sel = 3'd2; src = 64'h7; start = 1'b1;
    @(negedge clk); op_sel = 3'd2; src = 64'hF;
    check("R9 back-to-back first", result, 64'd3);
    check("R9 back-to-back valid", 64'(valid), 64'd1);
    @(negedge clk); start = 1'b0;
    check("R9 back-to-back second", result, 64'd4);
    @(negedge clk);
    check("R9 valid drops", 64'(valid), 64'd0);
    check("R9 result held", result, 64'd4);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R9: watchdog expired, actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule